// File: doc/BRIEF.md
# UART Register Front End with Prioritized Interrupt Identification

This block is the processor-facing register file of a 16450-style serial port. A 32-bit single-cycle bus selects one of eight word-aligned registers. Writes to the data register leave as a one-cycle byte strobe toward a transmitter. Bytes from a receiver arrive on a one-cycle strobe and are held until software reads them. The block keeps the line status flags, detects overrun, and stores the interrupt enables and the line, modem and divisor settings. It drives those settings out to the serial logic around it.

One level-sensitive interrupt line is driven from a registered four-level priority encoder. The encoder also supplies the identification code that software reads to find the source. Modem status bits come in as plain inputs. Baud generation, bit shifting and modem pin sampling are handled outside the block.

Top module: `uart_regfile`

## Requirements
- R1: The register index is bus address bits [4:2], and address bits [1:0] are ignored. Index 0 is data, 1 is interrupt enable, 2 is identification, 3 is line control, 4 is modem control, 5 is line status, 6 is modem status and 7 is divisor. Read data is combinational in the cycle of the access, and any read side effect takes place at the closing clock edge.
- R2: After reset the following values hold:
  - line status reads 0x60, with bit 5 holding-empty and bit 6 transmitter-empty set;
  - identification reads 0x01;
  - `irq` is 0 and `rx_ready` is 1;
  - `lcr_out`, `mcr_out` and `div_out` are 0;
  - `tx_valid` is 0.
- R3: A write to the data register raises `tx_valid` for exactly the one cycle after the write edge, with `tx_byte` equal to write data bits [7:0]. Line status bits 5 and 6 stay set.
- R4: A cycle with `rx_valid` high stores `rx_byte` and sets line status bit 0 (data ready). A data register read returns the held byte in bits [7:0] and clears data ready, unless a new byte arrives in the same cycle. `rx_ready` is high exactly while data ready is clear.
- R5: A byte that arrives while data ready is set sets line status bit 1 (overrun), unless the data register is read in that same cycle. The new byte replaces the held one, and data ready stays set.
- R6: A pulse on `err_parity`, `err_framing` or `err_break` sets line status bit 2, 3 or 4 respectively. A line status read clears bits 1 to 4 and leaves data ready unchanged. A set in the same cycle as the read wins.
- R7: The following registers store their writes and read back as 0:
  - interrupt enable, bits [3:0]: bit 0 receive data, bit 1 holding empty, bit 2 line error, bit 3 modem;
  - line control, bits [6:0], which drive `lcr_out`;
  - modem control, bits [1:0], which drive `mcr_out`;
  - divisor, bits [15:0], which drive `div_out`.
- R8: Writes to identification, line status and modem status change no state. A modem status read returns `msr_in`.
- R9: The interrupt source is chosen in this order, highest first:
  1. any of line status bits 1 to 4 with enable bit 2 gives code 3'b110;
  2. data ready with enable bit 0 gives code 3'b100;
  3. holding empty with enable bit 1 gives code 3'b010;
  4. any of `msr_in[3:0]` with enable bit 3 gives code 3'b000.

  With none of these the code is 3'b001 and `irq` is 0; otherwise `irq` is 1. The code reads in identification bits [2:0].
- R10: `irq` and the identification code are registered. They reflect the register and input state of the previous cycle, so they change one clock after the write, read or receive edge that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address, bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | High while no unread byte is held |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detect pulse |
| msr_in | input | 8 | Modem status bits, [3:0] are change flags |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| lcr_out | output | 7 | Line control setting |
| mcr_out | output | 2 | Modem control setting |
| div_out | output | 16 | Baud divisor setting |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume the following about the inputs:
- every bus access lasts one cycle, and its side effect belongs to that single edge;
- the error strobes and `rx_valid` are one-cycle events that need no handshake;
- `msr_in` may change at any cycle, because the encoder samples it every clock.

The stimulus keeps within these assumptions in three ways. It changes inputs only on the falling edge and holds each strobe for exactly one cycle. It reads the identification code only after waiting two edges once the last cause has changed. It clears data ready and the error flags before each priority vector, so that leftover state cannot mask the expected source.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int IDX_W   = 3;
  localparam int IDX_LSB = 2;
  localparam int ADDR_W  = IDX_LSB + IDX_W;

  typedef enum logic [IDX_W-1:0] {
    IDX_DATA  = 3'd0,
    IDX_IEN   = 3'd1,
    IDX_IID   = 3'd2,
    IDX_LCTL  = 3'd3,
    IDX_MCTL  = 3'd4,
    IDX_LSTAT = 3'd5,
    IDX_MSTAT = 3'd6,
    IDX_DIVR  = 3'd7
  } reg_idx_e;

  localparam logic [2:0] IID_NONE = 3'b001;
  localparam logic [2:0] IID_LINE = 3'b110;
  localparam logic [2:0] IID_RXD  = 3'b100;
  localparam logic [2:0] IID_TXE  = 3'b010;
  localparam logic [2:0] IID_MDM  = 3'b000;

  typedef struct packed {
    logic       pending;
    logic [2:0] code;
  } irq_sel_t;

  // Fixed four-level priority; lsr is the 7-bit line status vector,
  // ien bit0 rx data, bit1 tx empty, bit2 line error, bit3 modem.
  function automatic irq_sel_t pick_irq(input logic [6:0] lsr,
                                        input logic [3:0] ien,
                                        input logic [3:0] mdelta);
    irq_sel_t s;
    if ((|lsr[4:1]) && ien[2]) begin
      s = '{pending: 1'b1, code: IID_LINE};
    end else if (lsr[0] && ien[0]) begin
      s = '{pending: 1'b1, code: IID_RXD};
    end else if (lsr[5] && ien[1]) begin
      s = '{pending: 1'b1, code: IID_TXE};
    end else if ((|mdelta) && ien[3]) begin
      s = '{pending: 1'b1, code: IID_MDM};
    end else begin
      s = '{pending: 1'b0, code: IID_NONE};
    end
    return s;
  endfunction

endpackage

// File: rtl/uart_line_status.sv
module uart_line_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          err_par,
  input  logic          err_frm,
  input  logic          err_brk,
  input  logic          rd_data,
  input  logic          rd_lsr,
  output logic [DW-1:0] hold,
  output logic [6:0]    lsr
);

  logic          dr_q, oe_q, pe_q, fe_q, bi_q;
  logic [DW-1:0] hold_q;
  logic          overrun_evt;

  assign overrun_evt = rx_valid && dr_q && !rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      bi_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      if (rx_valid) begin
        hold_q <= rx_byte;
        dr_q   <= 1'b1;
      end else if (rd_data) begin
        dr_q   <= 1'b0;
      end
      if (overrun_evt)  oe_q <= 1'b1;
      else if (rd_lsr)  oe_q <= 1'b0;
      if (err_par)      pe_q <= 1'b1;
      else if (rd_lsr)  pe_q <= 1'b0;
      if (err_frm)      fe_q <= 1'b1;
      else if (rd_lsr)  fe_q <= 1'b0;
      if (err_brk)      bi_q <= 1'b1;
      else if (rd_lsr)  bi_q <= 1'b0;
    end
  end

  // Transmission completes at once, so both empty flags stay high.
  assign lsr  = {1'b1, 1'b1, bi_q, fe_q, pe_q, oe_q, dr_q};
  assign hold = hold_q;

  AST_RX_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> lsr[0]); // R4
  AST_READ_CLEARS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_valid) |=> !lsr[0]); // R4
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> (lsr[1] && lsr[0])); // R5
  AST_NO_SPURIOUS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr[1] && !overrun_evt) |=> !lsr[1]); // R5
  AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !overrun_evt && !err_par && !err_frm && !err_brk)
      |=> (lsr[4:1] == 4'b0000)); // R6

endmodule

// File: rtl/uart_irq_encode.sv
module uart_irq_encode
  import uart_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] lsr,
  input  logic [3:0] ien,
  input  logic [3:0] mdelta,
  output logic       irq,
  output logic [2:0] iid
);

  irq_sel_t nxt;
  logic     irq_q;
  logic [2:0] iid_q;
  logic     unused_lsr;

  assign nxt        = pick_irq(lsr, ien, mdelta);
  assign unused_lsr = lsr[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      iid_q <= IID_NONE;
    end else begin
      irq_q <= nxt.pending;
      iid_q <= nxt.code;
    end
  end

  assign irq = irq_q;
  assign iid = iid_q;

  AST_LINE_ERR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lsr[4:1]) && ien[2]) |=> (irq && iid == IID_LINE)); // R9
  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'b0000) |=> (!irq && iid == IID_NONE)); // R9
  AST_TX_EMPTY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr[5] && ien[1]) |=> irq); // R9

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int DW    = 8,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_byte,
  output logic              rx_ready,
  input  logic              err_parity,
  input  logic              err_framing,
  input  logic              err_break,
  input  logic [7:0]        msr_in,
  output logic              tx_valid,
  output logic [DW-1:0]     tx_byte,
  output logic [6:0]        lcr_out,
  output logic [1:0]        mcr_out,
  output logic [DIV_W-1:0]  div_out,
  output logic              irq
);

  reg_idx_e      idx;
  logic          rd, wr;
  logic          rd_data_evt, rd_lsr_evt, wr_data_evt;
  logic [3:0]    ien_q;
  logic [6:0]    lcr_q;
  logic [1:0]    mcr_q;
  logic [DIV_W-1:0] div_q;
  logic          tx_valid_q;
  logic [DW-1:0] tx_byte_q;
  logic [DW-1:0] hold;
  logic [6:0]    lsr;
  logic [2:0]    iid;
  logic          unused_bits;

  assign idx         = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
  assign rd          = bus_sel && !bus_we;
  assign wr          = bus_sel && bus_we;
  assign rd_data_evt = rd && (idx == IDX_DATA);
  assign rd_lsr_evt  = rd && (idx == IDX_LSTAT);
  assign wr_data_evt = wr && (idx == IDX_DATA);
  assign unused_bits = ^{bus_addr[IDX_LSB-1:0], bus_wdata[BUS_W-1:DIV_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q      <= '0;
      lcr_q      <= '0;
      mcr_q      <= '0;
      div_q      <= '0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= wr_data_evt;
      if (wr_data_evt) tx_byte_q <= bus_wdata[DW-1:0];
      if (wr) begin
        case (idx)
          IDX_IEN:  ien_q <= bus_wdata[3:0];
          IDX_LCTL: lcr_q <= bus_wdata[6:0];
          IDX_MCTL: mcr_q <= bus_wdata[1:0];
          IDX_DIVR: div_q <= bus_wdata[DIV_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (idx)
        IDX_DATA:  bus_rdata[DW-1:0] = hold;
        IDX_IID:   bus_rdata[2:0]    = iid;
        IDX_LSTAT: bus_rdata[6:0]    = lsr;
        IDX_MSTAT: bus_rdata[7:0]    = msr_in;
        default:   bus_rdata         = '0;
      endcase
    end
  end

  uart_line_status #(.DW(DW)) u_lsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .err_par  (err_parity),
    .err_frm  (err_framing),
    .err_brk  (err_break),
    .rd_data  (rd_data_evt),
    .rd_lsr   (rd_lsr_evt),
    .hold     (hold),
    .lsr      (lsr)
  );

  uart_irq_encode u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lsr    (lsr),
    .ien    (ien_q),
    .mdelta (msr_in[3:0]),
    .irq    (irq),
    .iid    (iid)
  );

  assign rx_ready = !lsr[0];
  assign tx_valid = tx_valid_q;
  assign tx_byte  = tx_byte_q;
  assign lcr_out  = lcr_q;
  assign mcr_out  = mcr_q;
  assign div_out  = div_q;

  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_evt |=> (tx_valid && tx_byte == $past(bus_wdata[DW-1:0]))); // R3
  AST_TX_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_evt |=> !tx_valid); // R3
  AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (idx == IDX_IEN || idx == IDX_LCTL || idx == IDX_MCTL || idx == IDX_DIVR))
      |-> (bus_rdata == '0)); // R7
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (idx == IDX_IID || idx == IDX_LSTAT || idx == IDX_MSTAT))
      |=> ($stable(ien_q) && $stable(lcr_q) && $stable(mcr_q) && $stable(div_q))); // R8
  AST_READY_DROPS_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_ready); // R4

endmodule

// File: tb/uart_regfile_test.sv
module uart_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready;
  logic        err_parity = 1'b0, err_framing = 1'b0, err_break = 1'b0;
  logic [7:0]  msr_in = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic [6:0]  lcr_out;
  logic [1:0]  mcr_out;
  logic [15:0] div_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .err_parity(err_parity), .err_framing(err_framing), .err_break(err_break),
    .msr_in(msr_in), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .lcr_out(lcr_out), .mcr_out(mcr_out), .div_out(div_out), .irq(irq)
  );

  // {ien[3:0], load_byte, parity_pulse, msr[7:0], expected code[2:0]}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {4'b0000, 1'b0, 1'b0, 8'h00, 3'b001},
    {4'b0010, 1'b0, 1'b0, 8'h00, 3'b010},
    {4'b1000, 1'b0, 1'b0, 8'h01, 3'b000},
    {4'b1000, 1'b0, 1'b0, 8'hF0, 3'b001},
    {4'b1111, 1'b1, 1'b1, 8'h0F, 3'b110},
    {4'b1011, 1'b1, 1'b0, 8'h02, 3'b100},
    {4'b1001, 1'b1, 1'b0, 8'h04, 3'b100},
    {4'b0100, 1'b1, 1'b0, 8'h00, 3'b001},
    {4'b0110, 1'b0, 1'b1, 8'h00, 3'b110},
    {4'b1010, 1'b0, 1'b0, 8'h08, 3'b010}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = val;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd_a(input logic [4:0] addr, output logic [31:0] val);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = addr;
    #1 val = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] idx, output logic [31:0] val);
    bus_rd_a({idx, 2'b00}, val);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2", "irq", {31'b0, irq}, 32'd0);
    check("R2", "rx_ready", {31'b0, rx_ready}, 32'd1);
    check("R2", "tx_valid", {31'b0, tx_valid}, 32'd0);
    check("R2", "config outs", {7'b0, lcr_out, mcr_out, div_out}, 32'd0);
    bus_rd(3'd5, r); check("R2", "line status", r, 32'h60);
    bus_rd(3'd2, r); check("R2", "ident", r, 32'h01);

    // R1 low address bits ignored
    bus_rd_a(5'h17, r); check("R1", "lsr via addr 0x17", r, 32'h60);

    // R7 write-only registers
    bus_wr(3'd3, 32'hFFFF_FF5A);
    bus_wr(3'd4, 32'hFFFF_FFFE);
    bus_wr(3'd7, 32'h1234_ABCD);
    check("R7", "lcr_out", {25'b0, lcr_out}, 32'h5A);
    check("R7", "mcr_out", {30'b0, mcr_out}, 32'h2);
    check("R7", "div_out", {16'b0, div_out}, 32'hABCD);
    bus_rd(3'd3, r); check("R7", "lcr reads zero", r, 32'h0);
    bus_rd(3'd4, r); check("R7", "mcr reads zero", r, 32'h0);
    bus_rd(3'd7, r); check("R7", "div reads zero", r, 32'h0);
    bus_rd(3'd1, r); check("R7", "ien reads zero", r, 32'h0);

    // R8 read-only registers ignore writes
    bus_wr(3'd5, 32'h0000_0000);
    bus_wr(3'd2, 32'h0000_00FF);
    bus_wr(3'd6, 32'h0000_00FF);
    bus_rd(3'd5, r); check("R8", "lsr after write", r, 32'h60);
    bus_rd(3'd2, r); check("R8", "ident after write", r, 32'h01);
    check("R8", "lcr_out unchanged", {25'b0, lcr_out}, 32'h5A);
    msr_in = 8'hA5;
    bus_rd(3'd6, r); check("R8", "msr reads input", r, 32'hA5);
    msr_in = 8'h00;

    // R3 transmit strobe
    bus_wr(3'd0, 32'hDEAD_BE3C);
    check("R3", "tx_valid high", {31'b0, tx_valid}, 32'd1);
    check("R3", "tx_byte", {24'b0, tx_byte}, 32'h3C);
    @(negedge clk);
    check("R3", "tx_valid one cycle", {31'b0, tx_valid}, 32'd0);
    bus_rd(3'd5, r); check("R3", "empty flags kept", r, 32'h60);

    // R4 receive and read
    send_byte(8'h5B);
    check("R4", "rx_ready low", {31'b0, rx_ready}, 32'd0);
    bus_rd(3'd5, r); check("R4", "data ready", r, 32'h61);
    bus_rd(3'd0, r); check("R4", "data read", r, 32'h5B);
    check("R4", "rx_ready back", {31'b0, rx_ready}, 32'd1);
    bus_rd(3'd5, r); check("R4", "dr cleared", r, 32'h60);

    // R5 overrun
    send_byte(8'h11);
    send_byte(8'h22);
    bus_rd(3'd5, r); check("R5", "overrun set", r, 32'h63);
    bus_rd(3'd5, r); check("R5", "overrun cleared by read", r, 32'h61);
    bus_rd(3'd0, r); check("R5", "newest byte kept", r, 32'h22);
    bus_rd(3'd5, r); check("R5", "clean after", r, 32'h60);

    // R6 error pulses and clear on read
    @(negedge clk); err_framing = 1'b1; err_break = 1'b1;
    @(negedge clk); err_framing = 1'b0; err_break = 1'b0;
    bus_rd(3'd5, r); check("R6", "frame+break", r, 32'h78);
    // read with a parity pulse in the same cycle: set wins
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {3'd5, 2'b00}; err_parity = 1'b1;
    #1 check("R6", "lsr read cleared prev", bus_rdata, 32'h60);
    @(negedge clk);
    bus_sel = 1'b0; err_parity = 1'b0;
    bus_rd(3'd5, r); check("R6", "parity set wins", r, 32'h64);
    bus_rd(3'd5, r); check("R6", "cleared", r, 32'h60);

    // R10 one-cycle lag of irq
    bus_wr(3'd1, 32'h2);
    check("R10", "irq not yet", {31'b0, irq}, 32'd0);
    @(negedge clk);
    check("R10", "irq after lag", {31'b0, irq}, 32'd1);
    bus_wr(3'd1, 32'h0);
    check("R10", "irq still high", {31'b0, irq}, 32'd1);
    @(negedge clk);
    check("R10", "irq drops", {31'b0, irq}, 32'd0);

    // R9 priority table
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      bus_wr(3'd1, 32'h0);
      msr_in = v[10:3];
      if (v[12]) send_byte(8'h40 + 8'(i));
      if (v[11]) begin
        @(negedge clk); err_parity = 1'b1;
        @(negedge clk); err_parity = 1'b0;
      end
      bus_wr(3'd1, {28'b0, v[16:13]});
      repeat (2) @(negedge clk);
      check("R9", $sformatf("irq vec %0d", i), {31'b0, irq},
            {31'b0, (v[2:0] != 3'b001)});
      bus_rd(3'd2, r);
      check("R9", $sformatf("code vec %0d", i), r, {29'b0, v[2:0]});
      bus_rd(3'd0, r);
      bus_rd(3'd5, r);
      msr_in = 8'h00;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule